// File: doc/BRIEF.md
# Security-Domain Guarded Indirect Target Predictor

This block is a direct-mapped predictor for the targets of indirect branches. At fetch time it receives a lookup made of the branch address, a global history value, the hardware-thread number and the privilege level. One cycle later it reports whether a trained entry matched and, if one did, the target that entry holds. Resolved branches from the execute stage train it: each update overwrites the single slot its address and history select.

Every entry records the security context it was trained in, so a prediction cannot cross domains. The privilege level is always part of the match. An isolation switch adds the thread number to the match. A barrier pulse starts a walk that invalidates the whole table, one slot per clock. A restricted-speculation switch, when raised, hides everything trained before it was raised. It does this with a one-bit generation stamp, and a background scrub removes entries whose stamp would otherwise come back into use. While a walk runs, the block reports busy, all lookups miss and updates are dropped.

Top module: `btb_domain_guard`

## Requirements
- R1: A lookup that matches a trained entry sets `pred_hit` in the clock cycle after the lookup is presented, and `pred_target` then holds the target of the most recent update to that entry. A lookup that matches nothing sets `pred_hit` to 0.
- R2: The slot index is the low `log2(ENTRIES)` bits of the address XORed with each `log2(ENTRIES)`-bit chunk of the history (with the defaults, pc[3:0] ^ hist[3:0] ^ hist[7:4]). The stored tag is the next `TAG_W` address bits (pc[9:4] with the defaults). An entry matches only when both its tag and its full stored history equal those of the lookup.
- R3: An update overwrites its slot completely. A previously trained branch that maps to the same slot no longer hits.
- R4: The privilege bit of the lookup must equal the privilege bit stored at training time.
- R5: While `iso_en` is 1, the thread number must also match. While `iso_en` is 0, any thread may use any entry.
- R6: When an update and a lookup select the same slot in the same cycle, the lookup reports the contents from before the update. The next lookup sees the new contents.
- R7: A `barrier_req` pulse raises `busy` from the next cycle for exactly ENTRIES cycles. Afterwards no entry trained before the pulse hits.
- R8: In the cycle of a barrier pulse or of a restricted-mode entry, and in every cycle while `busy` is 1, lookups return a miss and updates are discarded.
- R9: A 0-to-1 transition of `restrict_en` starts an ENTRIES-cycle scrub with `busy` set. While `restrict_en` stays 1, no entry trained before the latest transition hits, this holds across repeated entries into the mode, and entries trained inside the mode do hit.
- R10: While `restrict_en` is 0, the generation stamp is ignored, so entries that survived the last scrub hit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Lookup branch address |
| lk_hist | input | HIST_W | Lookup global history |
| lk_tid | input | TID_W | Lookup hardware thread |
| lk_priv | input | 1 | Lookup privilege level |
| up_valid | input | 1 | Resolved-branch update request |
| up_pc | input | PC_W | Update branch address |
| up_hist | input | HIST_W | Update global history |
| up_tid | input | TID_W | Update hardware thread |
| up_priv | input | 1 | Update privilege level |
| up_target | input | PC_W | Resolved target to store |
| barrier_req | input | 1 | Pulse: invalidate the whole table |
| iso_en | input | 1 | Thread-isolation switch |
| restrict_en | input | 1 | Restricted-speculation switch |
| pred_hit | output | 1 | Registered hit flag |
| pred_target | output | PC_W | Registered predicted target |
| busy | output | 1 | A flush or scrub walk is running |

## Verification
The bench fills all sixteen slots and then aims at the edges of the domain match. It uses two histories that fold to the same slot, so a design that leaves history out of the match would hit on the wrong one. It repeats a lookup with the other privilege level and with the other thread. It presents an update and a lookup in the same cycle, where a write-through design would show the new target too early. It counts busy cycles after a barrier to catch an off-by-one walk. It goes into restricted mode, out of it and back in, because a bare one-bit stamp without a scrub would bring back entries trained before the first entry. It also makes lookups in the exact cycle of a barrier or of a mode entry, where an ungated design would still predict from old training.

// File: rtl/btb_pkg.sv
package btb_pkg;
   typedef enum logic [1:0] {
      WALK_IDLE  = 2'd0,
      WALK_FULL  = 2'd1,
      WALK_SCRUB = 2'd2
   } walk_e;
endpackage

// File: rtl/btb_hash.sv
module btb_hash #(
   parameter int PC_W   = 16,
   parameter int HIST_W = 8,
   parameter int IDX_W  = 4,
   parameter int TAG_W  = 6
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [HIST_W-1:0] hist,
   output logic [IDX_W-1:0]  idx,
   output logic [TAG_W-1:0]  tag
);
   localparam int CHUNKS = (HIST_W + IDX_W - 1) / IDX_W;
   localparam int PADW   = CHUNKS * IDX_W;

   logic [PADW-1:0]               hpad;
   logic [CHUNKS:0][IDX_W-1:0]    acc;

   assign hpad   = PADW'(hist);
   assign acc[0] = pc[IDX_W-1:0];

   for (genvar g = 0; g < CHUNKS; g++) begin : g_fold
      assign acc[g+1] = acc[g] ^ hpad[g*IDX_W +: IDX_W];
   end

   assign idx = acc[CHUNKS];
   assign tag = pc[IDX_W +: TAG_W];
endmodule

// File: rtl/btb_walker.sv
module btb_walker
   import btb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             barrier_req,
   input  logic             restrict_en,
   output logic             busy,
   output logic             enter,
   output logic             clr_full,
   output logic             clr_scrub,
   output logic [IDX_W-1:0] clr_idx,
   output logic             epoch
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   walk_e            mode;
   logic [IDX_W-1:0] cnt;
   logic             restrict_q;

   assign enter     = restrict_en & ~restrict_q;
   assign busy      = (mode != WALK_IDLE);
   assign clr_full  = (mode == WALK_FULL);
   assign clr_scrub = (mode == WALK_SCRUB);
   assign clr_idx   = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode       <= WALK_IDLE;
         cnt        <= '0;
         restrict_q <= 1'b0;
         epoch      <= 1'b0;
      end else begin
         restrict_q <= restrict_en;
         if (enter) epoch <= ~epoch;
         if (barrier_req) begin
            mode <= WALK_FULL;
            cnt  <= '0;
         end else if (enter && mode != WALK_FULL) begin
            mode <= WALK_SCRUB;
            cnt  <= '0;
         end else if (mode != WALK_IDLE) begin
            if (cnt == LAST) begin
               mode <= WALK_IDLE;
               cnt  <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R7: a full walk ends right after its last slot
   a_r7_walk_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == WALK_FULL && cnt == LAST && !barrier_req) |=> (mode == WALK_IDLE));

   // R9: every entry into restricted mode starts a new generation
   a_r9_epoch_flip: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restrict_en) |=> (epoch != $past(epoch)));

   // R9: every entry into restricted mode leaves a walk running
   a_r9_scrub_runs: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restrict_en) |=> busy);
endmodule

// File: rtl/btb_store.sv
module btb_store #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4,
   parameter int TAG_W   = 6,
   parameter int HIST_W  = 8,
   parameter int TID_W   = 1,
   parameter int PC_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [TAG_W-1:0]  rd_tag,
   input  logic [HIST_W-1:0] rd_hist,
   input  logic [TID_W-1:0]  rd_tid,
   input  logic              rd_priv,
   input  logic              iso_en,
   input  logic              restrict_en,
   input  logic              epoch,
   output logic              rd_match,
   output logic [PC_W-1:0]   rd_target,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [HIST_W-1:0] wr_hist,
   input  logic [TID_W-1:0]  wr_tid,
   input  logic              wr_priv,
   input  logic [PC_W-1:0]   wr_target,
   input  logic              clr_full,
   input  logic              clr_scrub,
   input  logic [IDX_W-1:0]  clr_idx
);
   logic              vld    [ENTRIES];
   logic              e_ep   [ENTRIES];
   logic [TAG_W-1:0]  e_tag  [ENTRIES];
   logic [HIST_W-1:0] e_hist [ENTRIES];
   logic [TID_W-1:0]  e_tid  [ENTRIES];
   logic              e_priv [ENTRIES];
   logic [PC_W-1:0]   e_tgt  [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic hit_wr, hit_clr;
      assign hit_wr  = wr_en && (wr_idx == IDX_W'(g));
      assign hit_clr = (clr_idx == IDX_W'(g)) &&
                       (clr_full || (clr_scrub && e_ep[g] == epoch));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       vld[g] <= 1'b0;
         else if (hit_wr)  vld[g] <= 1'b1;
         else if (hit_clr) vld[g] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         e_ep[wr_idx]   <= epoch;
         e_tag[wr_idx]  <= wr_tag;
         e_hist[wr_idx] <= wr_hist;
         e_tid[wr_idx]  <= wr_tid;
         e_priv[wr_idx] <= wr_priv;
         e_tgt[wr_idx]  <= wr_target;
      end
   end

   always_comb begin
      rd_match = vld[rd_idx]
              && (e_tag[rd_idx]  == rd_tag)
              && (e_hist[rd_idx] == rd_hist)
              && (e_priv[rd_idx] == rd_priv)
              && (!iso_en      || e_tid[rd_idx] == rd_tid)
              && (!restrict_en || e_ep[rd_idx] == epoch);
      rd_target = e_tgt[rd_idx];
   end

   // R7: a slot visited by the full walk is empty afterwards
   a_r7_slot_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_full && !(wr_en && wr_idx == clr_idx)) |=> !vld[$past(clr_idx)]);

   // R3: a written slot is valid on the next cycle
   a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld[$past(wr_idx)]);
endmodule

// File: rtl/btb_domain_guard.sv
module btb_domain_guard #(
   parameter int PC_W    = 16,
   parameter int ENTRIES = 16,
   parameter int HIST_W  = 8,
   parameter int TAG_W   = 6,
   parameter int TID_W   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [PC_W-1:0]   lk_pc,
   input  logic [HIST_W-1:0] lk_hist,
   input  logic [TID_W-1:0]  lk_tid,
   input  logic              lk_priv,
   input  logic              up_valid,
   input  logic [PC_W-1:0]   up_pc,
   input  logic [HIST_W-1:0] up_hist,
   input  logic [TID_W-1:0]  up_tid,
   input  logic              up_priv,
   input  logic [PC_W-1:0]   up_target,
   input  logic              barrier_req,
   input  logic              iso_en,
   input  logic              restrict_en,
   output logic              pred_hit,
   output logic [PC_W-1:0]   pred_target,
   output logic              busy
);
   localparam int IDX_W = $clog2(ENTRIES);

   initial begin
      assert (ENTRIES >= 2 && (ENTRIES & (ENTRIES - 1)) == 0)
         else $error("ENTRIES must be a power of two of at least 2");
      assert (PC_W >= IDX_W + TAG_W)
         else $error("PC_W too small for index plus tag");
      assert (TAG_W >= 1 && HIST_W >= 1 && TID_W >= 1)
         else $error("field widths must be positive");
   end

   logic [IDX_W-1:0] rd_idx, wr_idx, clr_idx;
   logic [TAG_W-1:0] rd_tag, wr_tag;
   logic             rd_match, enter, clr_full, clr_scrub, epoch;
   logic [PC_W-1:0]  rd_target;
   logic             blocked, lk_ok, up_ok;

   btb_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash_rd (
      .pc(lk_pc), .hist(lk_hist), .idx(rd_idx), .tag(rd_tag));

   btb_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash_wr (
      .pc(up_pc), .hist(up_hist), .idx(wr_idx), .tag(wr_tag));

   btb_walker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_walker (
      .clk(clk), .rst_n(rst_n), .barrier_req(barrier_req), .restrict_en(restrict_en),
      .busy(busy), .enter(enter), .clr_full(clr_full), .clr_scrub(clr_scrub),
      .clr_idx(clr_idx), .epoch(epoch));

   assign blocked = busy | barrier_req | enter;
   assign lk_ok   = lk_valid & ~blocked;
   assign up_ok   = up_valid & ~blocked;

   btb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .HIST_W(HIST_W),
               .TID_W(TID_W), .PC_W(PC_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_hist(lk_hist), .rd_tid(lk_tid),
      .rd_priv(lk_priv), .iso_en(iso_en), .restrict_en(restrict_en), .epoch(epoch),
      .rd_match(rd_match), .rd_target(rd_target),
      .wr_en(up_ok), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_hist(up_hist),
      .wr_tid(up_tid), .wr_priv(up_priv), .wr_target(up_target),
      .clr_full(clr_full), .clr_scrub(clr_scrub), .clr_idx(clr_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_hit    <= 1'b0;
         pred_target <= '0;
      end else begin
         pred_hit    <= lk_ok & rd_match;
         pred_target <= (lk_ok & rd_match) ? rd_target : '0;
      end
   end

   // R8: no prediction leaves the block for a lookup made during a walk
   a_r8_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !pred_hit);

   // R8: a lookup in the barrier cycle misses
   a_r8_barrier_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      barrier_req |=> !pred_hit);

   // R9: a lookup in the mode-entry cycle misses
   a_r9_entry_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restrict_en) |=> !pred_hit);

   // R1: a hit always answers a lookup of the previous cycle
   a_r1_hit_has_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      pred_hit |-> $past(lk_valid));
endmodule

// File: tb/tb_btb_domain_guard.sv
module tb_btb_domain_guard;
   localparam int CLK_PERIOD = 10;
   localparam int PC_W = 16, ENTRIES = 16, HIST_W = 8, TAG_W = 6, TID_W = 1;

   logic clk = 1'b0;
   logic rst_n;
   logic lk_valid, lk_priv, up_valid, up_priv, barrier_req, iso_en, restrict_en;
   logic [PC_W-1:0]   lk_pc, up_pc, up_target, pred_target;
   logic [HIST_W-1:0] lk_hist, up_hist;
   logic [TID_W-1:0]  lk_tid, up_tid;
   logic pred_hit, busy;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   btb_domain_guard #(.PC_W(PC_W), .ENTRIES(ENTRIES), .HIST_W(HIST_W), .TAG_W(TAG_W),
                      .TID_W(TID_W)) dut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hist(lk_hist),
      .lk_tid(lk_tid), .lk_priv(lk_priv), .up_valid(up_valid), .up_pc(up_pc),
      .up_hist(up_hist), .up_tid(up_tid), .up_priv(up_priv), .up_target(up_target),
      .barrier_req(barrier_req), .iso_en(iso_en), .restrict_en(restrict_en),
      .pred_hit(pred_hit), .pred_target(pred_target), .busy(busy));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic upd(input logic [15:0] pc, input logic [7:0] h, input logic t,
                      input logic p, input logic [15:0] tgt);
      @(negedge clk);
      up_pc = pc; up_hist = h; up_tid = t; up_priv = p; up_target = tgt; up_valid = 1'b1;
      @(negedge clk);
      up_valid = 1'b0;
   endtask

   task automatic look(input string req, input logic [15:0] pc, input logic [7:0] h,
                       input logic t, input logic p, input logic exp_hit,
                       input logic [15:0] exp_tgt);
      @(negedge clk);
      lk_pc = pc; lk_hist = h; lk_tid = t; lk_priv = p; lk_valid = 1'b1;
      @(negedge clk);
      lk_valid = 1'b0;
      check(req, pred_hit, exp_hit);
      if (exp_hit) check(req, pred_target, exp_tgt);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   function automatic logic [15:0] sweep_pc(input int i);
      return 16'((i << 4) | i);
   endfunction

   function automatic logic [15:0] sweep_tgt(input int i);
      return 16'(i * 37 + 5);
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int cnt;
      rst_n = 1'b0; lk_valid = 0; up_valid = 0; barrier_req = 0; iso_en = 0; restrict_en = 0;
      lk_pc = '0; lk_hist = '0; lk_tid = '0; lk_priv = 0;
      up_pc = '0; up_hist = '0; up_tid = '0; up_priv = 0; up_target = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset hit", pred_hit, 0);
      check("R7 reset busy", busy, 0);
      look("R1 empty table", 16'h0055, 8'h00, 0, 0, 0, 0);

      // R1/R3: fill every slot, read every slot back
      for (int i = 0; i < ENTRIES; i++) upd(sweep_pc(i), 8'h00, 0, 0, sweep_tgt(i));
      for (int i = 0; i < ENTRIES; i++) look("R1 sweep", sweep_pc(i), 8'h00, 0, 0, 1, sweep_tgt(i));
      // R2: same slot, other tag
      for (int i = 0; i < ENTRIES; i++)
         look("R2 tag mismatch", 16'((((i + 1) % 16) << 4) | i), 8'h00, 0, 0, 0, 0);

      // R2: folded history: 3 ^ 1 ^ 2 = slot 0
      upd(16'h0003, 8'h21, 0, 0, 16'hBEEF);
      look("R2 folded hit", 16'h0003, 8'h21, 0, 0, 1, 16'hBEEF);
      look("R3 slot 0 replaced", 16'h0000, 8'h00, 0, 0, 0, 0);
      look("R2 history mismatch", 16'h0003, 8'h12, 0, 0, 0, 0);
      upd(16'h0003, 8'h21, 0, 0, 16'hCAFE);
      look("R3 retrain", 16'h0003, 8'h21, 0, 0, 1, 16'hCAFE);

      // R4 privilege
      look("R4 priv mismatch", sweep_pc(5), 8'h00, 0, 1, 0, 0);
      upd(sweep_pc(6), 8'h00, 0, 1, 16'h1234);
      look("R4 priv match", sweep_pc(6), 8'h00, 0, 1, 1, 16'h1234);
      look("R4 priv user now misses", sweep_pc(6), 8'h00, 0, 0, 0, 0);

      // R5 thread isolation
      look("R5 shared", sweep_pc(5), 8'h00, 1, 0, 1, sweep_tgt(5));
      iso_en = 1'b1;
      look("R5 isolated other", sweep_pc(5), 8'h00, 1, 0, 0, 0);
      look("R5 isolated own", sweep_pc(5), 8'h00, 0, 0, 1, sweep_tgt(5));
      iso_en = 1'b0;

      // R6 same-cycle update and lookup
      @(negedge clk);
      up_pc = sweep_pc(7); up_hist = 0; up_tid = 0; up_priv = 0; up_target = 16'h7777;
      up_valid = 1'b1;
      lk_pc = sweep_pc(7); lk_hist = 0; lk_tid = 0; lk_priv = 0; lk_valid = 1'b1;
      @(negedge clk);
      up_valid = 0; lk_valid = 0;
      check("R6 old hit", pred_hit, 1);
      check("R6 old target", pred_target, sweep_tgt(7));
      look("R6 new contents", sweep_pc(7), 8'h00, 0, 0, 1, 16'h7777);

      // R7/R8 barrier
      @(negedge clk);
      barrier_req = 1'b1;
      lk_pc = sweep_pc(1); lk_hist = 0; lk_tid = 0; lk_priv = 0; lk_valid = 1'b1;
      @(negedge clk);
      barrier_req = 1'b0; lk_valid = 1'b0;
      check("R8 barrier-cycle lookup", pred_hit, 0);
      cnt = 0;
      for (int k = 0; k < 20; k++) begin
         if (busy) cnt++;
         if (k == 2) begin
            up_pc = 16'h0ABC; up_hist = 0; up_tid = 0; up_priv = 0; up_target = 16'h4444;
            up_valid = 1'b1;
         end
         if (k == 3) up_valid = 1'b0;
         if (k == 4) begin
            lk_pc = sweep_pc(15); lk_valid = 1'b1;
         end
         if (k == 5) begin
            lk_valid = 1'b0;
            check("R8 busy lookup", pred_hit, 0);
         end
         @(negedge clk);
      end
      check("R7 busy length", cnt, ENTRIES);
      for (int i = 1; i < ENTRIES; i++) look("R7 flushed", sweep_pc(i), 8'h00, 0, 0, 0, 0);
      look("R7 folded flushed", 16'h0003, 8'h21, 0, 0, 0, 0);
      look("R8 busy update dropped", 16'h0ABC, 8'h00, 0, 0, 0, 0);

      // R9/R10 restricted speculation
      upd(16'h0011, 8'h00, 0, 0, 16'hA0A0);
      look("R9 pre-mode hit", 16'h0011, 8'h00, 0, 0, 1, 16'hA0A0);
      @(negedge clk);
      restrict_en = 1'b1;
      lk_pc = 16'h0011; lk_hist = 0; lk_tid = 0; lk_priv = 0; lk_valid = 1'b1;
      @(negedge clk);
      lk_valid = 1'b0;
      check("R9 entry-cycle lookup", pred_hit, 0);
      cnt = 0;
      for (int k = 0; k < 20; k++) begin
         if (busy) cnt++;
         @(negedge clk);
      end
      check("R9 scrub length", cnt, ENTRIES);
      look("R9 old hidden", 16'h0011, 8'h00, 0, 0, 0, 0);
      upd(16'h0022, 8'h00, 0, 0, 16'hB0B0);
      look("R9 in-mode hit", 16'h0022, 8'h00, 0, 0, 1, 16'hB0B0);
      @(negedge clk);
      restrict_en = 1'b0;
      look("R10 old back", 16'h0011, 8'h00, 0, 0, 1, 16'hA0A0);
      upd(16'h0033, 8'h00, 0, 0, 16'hC0C0);
      look("R10 new entry", 16'h0033, 8'h00, 0, 0, 1, 16'hC0C0);
      @(negedge clk);
      restrict_en = 1'b1;
      @(negedge clk);
      wait_idle();
      look("R9 reentry first", 16'h0011, 8'h00, 0, 0, 0, 0);
      look("R9 reentry second", 16'h0022, 8'h00, 0, 0, 0, 0);
      look("R9 reentry third", 16'h0033, 8'h00, 0, 0, 0, 0);
      upd(16'h0044, 8'h00, 0, 0, 16'hD0D0);
      look("R9 reentry trained", 16'h0044, 8'h00, 0, 0, 1, 16'hD0D0);
      @(negedge clk);
      restrict_en = 1'b0;
      look("R10 scrubbed stays gone", 16'h0011, 8'h00, 0, 0, 0, 0);
      look("R10 survivor", 16'h0022, 8'h00, 0, 0, 1, 16'hB0B0);
      look("R10 survivor two", 16'h0033, 8'h00, 0, 0, 1, 16'hC0C0);
      look("R10 latest", 16'h0044, 8'h00, 0, 0, 1, 16'hD0D0);

      finish_run();
   end
endmodule